// File: doc/BRIEF.md
# Byte-Serial SPI Master with Two-Step Flag Clear

This block is an SPI master that moves one byte per transfer. It sits behind a small register bus with three registers: control, status and data. Firmware writes a byte to the data register, and the block shifts it out on the serial clock and data-out lines, most significant bit first. At the same time it gathers the byte arriving on the serial data-in line. When the eighth bit has been exchanged, the received byte becomes readable and a completion flag goes up. Firmware drives the slave-select line itself through a general-purpose output that lies outside this block.

The interrupt request is a level: the completion flag ANDed with an enable bit. Taking the interrupt does not clear the flag, and writing ones to the status register does not clear it either. The flag drops only after a specific sequence. First, the status register is read while a flag is set, which arms the clear. Then the data register is read or written. A handler that touches only the data register leaves the request asserted, so the interrupt fires again at once. A transfer that finishes while the clear is armed keeps the flag set and disarms it, so the new completion cannot be lost.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control and status registers read 0x00, the interrupt output is low, and the serial clock is low.
- R2: A write to the data register (address 2) while idle starts a transfer. The written byte appears on the data-out line most significant bit first, and status bit 0 (busy) reads 1 until the transfer ends.
- R3: Control bits [2:0] hold a divider exponent d. Each serial-clock half period lasts 2^d system clocks. The completion flag rises exactly 16·2^d clocks after the clock edge that accepted the data write.
- R4: Control bit 5 sets the serial-clock idle level. Control bit 4 selects the sampling edge: when it is 0 the input is sampled on the leading edge, and when it is 1 it is sampled on the trailing edge. Data-out changes on the opposite edge.
- R5: At the end of a transfer, the received byte reads back from the data register and status bit 7 (done) is set.
- R6: The interrupt output equals status bit 7 ANDed with control bit 7 (interrupt enable), with no clock delay.
- R7: Done and collision clear only when a data-register read or write follows a status read that was made while either flag was set. A data access without that prior status read leaves the flags set.
- R8: A write to the status register, including all ones, changes no flag.
- R9: If a transfer completes while the clear is armed, the done flag stays set and the clear is disarmed. The next data access then leaves the flag set.
- R10: A data write while busy is ignored: the transfer in progress continues with its original byte. Status bit 6 (collision) is set.
- R11: A status read while both flags are clear does not arm the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status and data reads have side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register, combinational |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest situation to reach from the ports is a completion that lands while the clear is armed. The flag must already be set, a second transfer must be started without clearing it, and the status register must be read during that second transfer. The bench builds this directly. It leaves the first completion uncleared, starts another transfer with a bare data write, and reads status part-way through. It then confirms that a data read after the second completion leaves the interrupt asserted. The collision case is reached in a similar way, by writing the data register in the middle of a transfer and checking that the bench's slave model still receives the original byte.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DW   = 8,
  parameter int DIVW = 3,
  parameter int AW   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          irq
);
  localparam int EW = $clog2(2 * DW);
  localparam int CW = (1 << DIVW) - 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(2 * DW - 1);
  localparam int IE_B = 7, CPOL_B = 5, CPHA_B = 4;

  logic [DW-1:0] ctrl_q, tx_sh, rx_sh, rx_q;
  logic [EW-1:0] edge_cnt;
  logic [CW-1:0] cnt, lim;
  logic busy, done, col, armed, sck_q;

  wire ie   = ctrl_q[IE_B];
  wire cpol = ctrl_q[CPOL_B];
  wire cpha = ctrl_q[CPHA_B];
  wire [DIVW-1:0] div = ctrl_q[DIVW-1:0];

  wire sel_ctrl = addr == AW'(0);
  wire sel_stat = addr == AW'(1);
  wire sel_data = addr == AW'(2);
  wire data_wr  = wr_en & sel_data;
  wire data_acc = data_wr | (rd_en & sel_data);
  wire stat_rd  = rd_en & sel_stat;
  wire start    = data_wr & ~busy;
  wire collide  = data_wr & busy;
  wire clr_seq  = armed & data_acc;

  assign lim = CW'((1 << div) - 1);
  wire half_end  = busy && (cnt == lim);
  wire leading   = ~edge_cnt[0];
  wire sample_e  = half_end && (leading ^ cpha);
  wire shift_e   = half_end && !(leading ^ cpha) && !(cpha && edge_cnt == '0);
  wire finish    = half_end && (edge_cnt == LAST_EDGE);
  wire [DW-1:0] rx_next = {rx_sh[DW-2:0], miso};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && sel_ctrl) ctrl_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; edge_cnt <= '0;
      tx_sh <= '0; rx_sh <= '0; rx_q <= '0; sck_q <= 1'b0;
    end else begin
      if (start) begin
        busy <= 1'b1; cnt <= '0; edge_cnt <= '0; tx_sh <= wdata;
      end else if (busy) begin
        cnt <= half_end ? '0 : cnt + 1'b1;
        if (half_end) edge_cnt <= edge_cnt + 1'b1;
        if (sample_e) rx_sh <= rx_next;
        if (shift_e) tx_sh <= {tx_sh[DW-2:0], 1'b0};
        if (finish) begin
          busy <= 1'b0;
          rx_q <= sample_e ? rx_next : rx_sh;
        end
      end
      if (half_end) sck_q <= ~sck_q;
      else if (!busy) sck_q <= cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; col <= 1'b0; armed <= 1'b0;
    end else begin
      if (finish) done <= 1'b1;
      else if (clr_seq) done <= 1'b0;
      if (collide) col <= 1'b1;
      else if (clr_seq) col <= 1'b0;
      if (finish || clr_seq) armed <= 1'b0;
      else if (stat_rd && (done || col)) armed <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl) rdata = ctrl_q;
    else if (sel_stat) begin
      rdata[DW-1] = done;
      rdata[DW-2] = col;
      rdata[0]    = busy;
    end else if (sel_data) rdata = rx_q;
  end

  assign sck  = sck_q;
  assign mosi = tx_sh[DW-1];
  assign irq  = done & ie;

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(armed && data_acc) |=> done);
  assert_clear_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(armed && data_acc));
  assert_end_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done && !armed);
  assert_collide_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && data_wr |=> col && (busy || done));
  assert_arm_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(stat_rd && (done || col)));
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> sck == $past(cpol));
endmodule

// File: tb/sim_spi_byte_master.sv
module sim_spi_byte_master;
  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic sck, mosi, miso, irq;
  int checks = 0, errors = 0;
  bit finished = 0;

  logic [7:0] s_tx = 0, s_rx = 0;
  int s_cnt = 0;
  bit s_act = 0, s_cpol = 0, s_cpha = 0;

  always #4 clk = ~clk;

  spi_byte_master u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sck(sck), .mosi(mosi), .miso(miso), .irq(irq));

  assign miso = s_tx[7];

  always @(sck) begin
    if (s_act) begin
      if ((sck != s_cpol) ^ s_cpha) s_rx = {s_rx[6:0], mosi};
      else if (!(s_cpha && s_cnt == 0)) s_tx = s_tx << 1;
      s_cnt++;
    end
  end

  function automatic int half_of(input int d); return 1 << d; endfunction
  function automatic bit exp_irq(input bit flag, input bit en); return flag & en; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic wr(input [1:0] a, input [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input [1:0] a, output [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic set_ctrl(input bit en, input bit pol, input bit pha, input int d);
    wr(0, {en, 1'b0, pol, pha, 1'b0, 3'(d)});
    s_cpol = pol; s_cpha = pha;
    repeat (2) @(negedge clk);
  endtask

  task automatic arm_slave(input [7:0] b);
    s_tx = b; s_rx = 0; s_cnt = 0; s_act = 1;
  endtask

  task automatic xfer(input [7:0] tb, input [7:0] sb, input int d, input bit en);
    logic [7:0] v;
    arm_slave(sb);
    wr(2, tb);
    repeat (16 * half_of(d) - 1) @(negedge clk);
    chk(irq == 1'b0, "R3 early", irq, 0);
    @(negedge clk);
    chk(irq == exp_irq(1, en), "R3/R6 irq at end", irq, exp_irq(1, en));
    chk(sck == s_cpol, "R4 idle level", sck, s_cpol);
    chk(s_rx == tb, "R2 slave got byte", s_rx, tb);
    s_act = 0;
    @(negedge clk); addr = 2; #1 v = rdata;
    chk(v == sb, "R5 rx byte", v, sb);
  endtask

  task automatic clear_flags();
    logic [7:0] v;
    rd(1, v); rd(2, v);
    #1 chk(irq == 0, "R7 clear sequence", irq, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    addr = 0; #1 chk(rdata == 0, "R1 ctrl", rdata, 0);
    addr = 1; #1 chk(rdata == 0, "R1 status", rdata, 0);
    chk(irq == 0 && sck == 0, "R1 outputs", {irq, sck}, 0);
    rst_n = 1;

    set_ctrl(1, 0, 0, 1);
    xfer(8'hA5, 8'h3C, 1, 1);
    @(negedge clk); addr = 1; #1 chk(rdata == 8'h80, "R5 status done", rdata, 8'h80);
    wr(1, 8'hFF);
    #1 chk(irq == 1, "R8 status write ignored", irq, 1);
    rd(2, v);
    #1 chk(irq == 1, "R7 data read without status read", irq, 1);
    wr(0, 8'h01);
    #1 chk(irq == 0, "R6 enable off", irq, 0);
    wr(0, 8'h81);
    #1 chk(irq == 1, "R6 enable on", irq, 1);
    clear_flags();
    @(negedge clk); addr = 1; #1 chk(rdata == 0, "R7 status after clear", rdata, 0);

    rd(1, v);
    xfer(8'h5A, 8'hC3, 1, 1);
    rd(2, v);
    #1 chk(irq == 1, "R11 idle status read not armed", irq, 1);
    clear_flags();

    set_ctrl(1, 1, 1, 2);
    arm_slave(8'h96);
    wr(2, 8'h71);
    repeat (10) @(negedge clk);
    wr(2, 8'hFF);
    rd(1, v);
    chk(v == 8'h41, "R10 collision bit", v, 8'h41);
    repeat (64) @(negedge clk);
    chk(s_rx == 8'h71, "R10 original byte kept", s_rx, 8'h71);
    s_act = 0;
    rd(2, v);
    chk(v == 8'h96, "R4 mode 3 rx", v, 8'h96);
    #1 chk(irq == 1, "R9 collision arm dropped at end", irq, 1);
    rd(1, v);
    chk(v == 8'hC0, "R10 status both flags", v, 8'hC0);
    rd(2, v);
    @(negedge clk); addr = 1; #1 chk(rdata == 0, "R7 both cleared", rdata, 0);

    set_ctrl(1, 0, 1, 0);
    xfer(8'h0F, 8'hF0, 0, 1);
    arm_slave(8'h12);
    wr(2, 8'h34);
    #1 chk(irq == 1, "R7 bare data write keeps flag", irq, 1);
    rd(1, v);
    chk(v == 8'h81, "R9 status mid transfer", v, 8'h81);
    repeat (20) @(negedge clk);
    s_act = 0;
    rd(2, v);
    chk(v == 8'h12, "R9 second rx", v, 8'h12);
    #1 chk(irq == 1, "R9 completion while armed keeps flag", irq, 1);
    clear_flags();

    for (int i = 0; i < 24; i++) begin
      int d = $urandom % 3;
      bit pol = $urandom % 2, pha = $urandom % 2, en = $urandom % 2;
      logic [7:0] tb = 8'($urandom), sb = 8'($urandom);
      set_ctrl(en, pol, pha, d);
      xfer(tb, sb, d, en);
      wr(0, {1'b1, 2'b0, pol, pha, 3'(d)});
      clear_flags();
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial void'($urandom(32'h5EED));
endmodule